// File: doc/BRIEF.md
# Stereo Attenuation Ramp Controller

This block sets the attenuation of the left and right channels of a stereo DAC path. For each channel it keeps the 8-bit attenuation code currently in force and moves that code toward a requested target. Each code step is 0.5 dB. A soft mode steps the code one unit at a time, at a rate measured in sample periods. A zero-cross mode applies the whole change in one jump, either on a zero crossing of that channel's data or after a bounded wait.

Each channel has its own zero-crossing detector, timeout counter and zero-run detector. Three sources can mute a channel: the shared active-low soft-mute pin, the channel's own mute bit, and automatic muting after a long run of silent samples. The pin and the mute bit raise the effective target to the mute code and take the path chosen by the mode bit. Automatic muting is immediate.

Each channel has a per-channel finite state machine with four states:
- `ST_HOLD`: the code equals the effective target.
- `ST_RAMP`: the code is stepping once every N sample strobes.
- `ST_ZWAIT`: a jump is waiting for a crossing or the timeout.
- `ST_AMUTE`: the channel is muted because of a zero run.

The state machine takes these transitions:
- hold→ramp or hold→zwait when the code differs from the target, picked by the mode bit.
- ramp→zwait or zwait→ramp when the mode bit changes.
- ramp→hold or zwait→hold when the target is reached.
- any→amute on the last sample of a zero run.
- amute→hold on a non-silent sample, or when the zero-mute disable bit is set.

Top module: `atten_ramp_ctrl`

## Requirements
- R1: The code range is 0 (no attenuation) to 227 (113.5 dB). The mute code is 228. A target above 227 is treated as 228. The mute flag is high exactly when the code is above 227.
- R2: In soft mode (`zc_mode`=0) the code moves by one toward the effective target once every N sample strobes and stops at the target.
- R3: The rate select gives N as follows: 0→8, 1→4, 2→16, 3→32. The tick count restarts when a ramp starts.
- R4: In zero-cross mode (`zc_mode`=1) the code jumps to the target in one step, on a strobe whose sample is zero or whose sign bit (bit 19) differs from the sign of the previous strobed sample. The code never changes in a cycle with no strobe, except when a channel leaves auto-mute through the disable bit.
- R5: In zero-cross mode, if no crossing occurs, the jump happens on the 512th strobe counted from the start of the wait.
- R6: A write strobe sets that channel's pending flag in the next cycle. The flag clears one cycle after the code has settled at the effective target.
- R7: Holding `smute_n` low drives both channels to the mute code, using the mode chosen by `zc_mode`. Raising it returns both channels to their programmed targets the same way.
- R8: A channel's mute bit drives only that channel to the mute code, using the ramp or zero-cross rule chosen by `zc_mode`.
- R9: On the 512th consecutive strobed sample that is all zeros or all ones, the code goes to 228 at once. The first strobed sample of any other value returns the code to the effective target at once.
- R10: While `zmute_dis` is 1, runs of silent samples never cause auto-mute.
- R11: Writing a new target while a zero-cross change is pending restarts the 512-strobe timeout from zero.
- R12: After synchronous reset, both codes are 0, both pending flags are 0, both mute flags are 0 and the zero-run counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tgt_l | input | 8 | Left target attenuation code |
| tgt_r | input | 8 | Right target attenuation code |
| tgt_wr_l | input | 1 | Pulse: new left target written |
| tgt_wr_r | input | 1 | Pulse: new right target written |
| rate_sel | input | 2 | Ramp rate select |
| zc_mode | input | 1 | 0 = soft ramp, 1 = zero-cross jump |
| mute_l | input | 1 | Left mute bit |
| mute_r | input | 1 | Right mute bit |
| smute_n | input | 1 | Soft-mute pin, active low, both channels |
| zmute_dis | input | 1 | 1 disables mute on silent runs |
| smp_stb | input | 1 | One-cycle strobe per sample period |
| smp_l | input | 20 | Left sample, two's complement |
| smp_r | input | 20 | Right sample, two's complement |
| att_l | output | 8 | Left code in effect |
| att_r | output | 8 | Right code in effect |
| muted_l | output | 1 | Left channel muted |
| muted_r | output | 1 | Right channel muted |
| pend_l | output | 1 | Left change pending |
| pend_r | output | 1 | Right change pending |

## Verification
The hardest state to reach is a zero-cross wait that runs to its timeout after being restarted partway. That needs hundreds of strobes whose sign never flips, and the sign history must be primed before the target is written. The stimulus first sends same-sign samples, then writes a target, then rewrites it after 300 strobes. It then checks that the code has not moved after 511 further strobes and has jumped after the 512th. The 512-sample silent run is reached in a similar way, by alternating all-zero and all-one words, and its boundary is checked one sample before and at the run's end.

// File: rtl/atten_pkg.sv
`timescale 1ns/1ps
package atten_pkg;
    typedef enum logic [1:0] {
        ST_HOLD,
        ST_RAMP,
        ST_ZWAIT,
        ST_AMUTE
    } ch_state_e;
endpackage

// File: rtl/att_zero_watch.sv
`timescale 1ns/1ps
module att_zero_watch #(
    parameter int SMP_W   = 20,
    parameter int RUN_LEN = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_stb,
    input  logic [SMP_W-1:0] smp,
    input  logic             zdis,
    output logic             zc,
    output logic             run_hit,
    output logic             nz
);
    localparam int RUN_W = $clog2(RUN_LEN);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

    logic             prev_sign;
    logic [RUN_W-1:0] run_q;
    logic             silent;

    always_comb begin
        silent  = (smp == '0) || (smp == '1);
        zc      = (smp == '0) || (smp[SMP_W-1] != prev_sign);
        run_hit = smp_stb && silent && (run_q == RUN_LAST) && !zdis;
        nz      = smp_stb && !silent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sign <= 1'b0;
            run_q     <= '0;
        end else if (smp_stb) begin
            prev_sign <= smp[SMP_W-1];
            if (!silent)               run_q <= '0;
            else if (run_q != RUN_LAST) run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/att_chan_fsm.sv
`timescale 1ns/1ps
module att_chan_fsm
    import atten_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int MAX_ATT = 227,
    parameter int TMO_SMP = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] tgt,
    input  logic              wr,
    input  logic              mute_req,
    input  logic              zc_mode,
    input  logic [1:0]        rate_sel,
    input  logic              zdis,
    input  logic              smp_stb,
    input  logic              zc,
    input  logic              run_hit,
    input  logic              nz,
    output logic [CODE_W-1:0] att,
    output logic              muted,
    output logic              pend
);
    localparam logic [CODE_W-1:0] MUTE_CODE = CODE_W'(MAX_ATT + 1);
    localparam int TMR_W = $clog2(TMO_SMP);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMO_SMP - 1);

    ch_state_e         state_q, state_d;
    logic [CODE_W-1:0] cur_q, cur_d, eff, step_code;
    logic [4:0]        tick_q, tick_d, tick_last;
    logic [TMR_W-1:0]  tmr_q, tmr_d;
    logic              pend_q;

    always_comb begin
        if (mute_req || tgt > MUTE_CODE) eff = MUTE_CODE;
        else                             eff = tgt;
        step_code = (cur_q < eff) ? cur_q + 1'b1 : cur_q - 1'b1;
        unique case (rate_sel)
            2'd0:    tick_last = 5'd7;
            2'd1:    tick_last = 5'd3;
            2'd2:    tick_last = 5'd15;
            default: tick_last = 5'd31;
        endcase
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        tick_d  = tick_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            ST_HOLD: begin
                if (run_hit) begin
                    state_d = ST_AMUTE;
                    cur_d   = MUTE_CODE;
                end else if (cur_q != eff) begin
                    if (zc_mode) begin
                        state_d = ST_ZWAIT;
                        tmr_d   = '0;
                    end else begin
                        state_d = ST_RAMP;
                        tick_d  = '0;
                    end
                end
            end
            ST_RAMP: begin
                if (run_hit) begin
                    state_d = ST_AMUTE;
                    cur_d   = MUTE_CODE;
                end else if (cur_q == eff) begin
                    state_d = ST_HOLD;
                end else if (zc_mode) begin
                    state_d = ST_ZWAIT;
                    tmr_d   = '0;
                end else if (smp_stb) begin
                    if (tick_q == tick_last) begin
                        tick_d = '0;
                        cur_d  = step_code;
                        if (step_code == eff) state_d = ST_HOLD;
                    end else begin
                        tick_d = tick_q + 1'b1;
                    end
                end
            end
            ST_ZWAIT: begin
                if (run_hit) begin
                    state_d = ST_AMUTE;
                    cur_d   = MUTE_CODE;
                end else if (cur_q == eff) begin
                    state_d = ST_HOLD;
                end else if (!zc_mode) begin
                    state_d = ST_RAMP;
                    tick_d  = '0;
                end else if (smp_stb && (zc || tmr_q == TMR_LAST)) begin
                    cur_d   = eff;
                    state_d = ST_HOLD;
                end else if (wr) begin
                    tmr_d = '0;
                end else if (smp_stb) begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            ST_AMUTE: begin
                if (zdis || nz) begin
                    cur_d   = eff;
                    state_d = ST_HOLD;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            tick_q <= '0;
            tmr_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            tick_q <= tick_d;
            tmr_q  <= tmr_d;
            if (wr)                                   pend_q <= 1'b1;
            else if (state_q == ST_HOLD && cur_q == eff) pend_q <= 1'b0;
        end
    end

    assign att   = cur_q;
    assign muted = cur_q > CODE_W'(MAX_ATT);
    assign pend  = pend_q;
endmodule

// File: rtl/atten_ramp_ctrl.sv
`timescale 1ns/1ps
module atten_ramp_ctrl #(
    parameter int SMP_W    = 20,
    parameter int CODE_W   = 8,
    parameter int MAX_ATT  = 227,
    parameter int TMO_SMP  = 512,
    parameter int ZRUN_LEN = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] tgt_l,
    input  logic [CODE_W-1:0] tgt_r,
    input  logic              tgt_wr_l,
    input  logic              tgt_wr_r,
    input  logic [1:0]        rate_sel,
    input  logic              zc_mode,
    input  logic              mute_l,
    input  logic              mute_r,
    input  logic              smute_n,
    input  logic              zmute_dis,
    input  logic              smp_stb,
    input  logic [SMP_W-1:0]  smp_l,
    input  logic [SMP_W-1:0]  smp_r,
    output logic [CODE_W-1:0] att_l,
    output logic [CODE_W-1:0] att_r,
    output logic              muted_l,
    output logic              muted_r,
    output logic              pend_l,
    output logic              pend_r
);
    localparam int NCH = 2;

    logic [CODE_W-1:0] tgt_a [NCH];
    logic [CODE_W-1:0] att_a [NCH];
    logic [SMP_W-1:0]  smp_a [NCH];
    logic [NCH-1:0]    wr_a, mbit_a, muted_a, pend_a;

    assign tgt_a[0] = tgt_l;
    assign tgt_a[1] = tgt_r;
    assign smp_a[0] = smp_l;
    assign smp_a[1] = smp_r;
    assign wr_a     = {tgt_wr_r, tgt_wr_l};
    assign mbit_a   = {mute_r, mute_l};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic zc, run_hit, nz;

        att_zero_watch #(.SMP_W(SMP_W), .RUN_LEN(ZRUN_LEN)) u_watch (
            .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp(smp_a[ch]),
            .zdis(zmute_dis), .zc(zc), .run_hit(run_hit), .nz(nz)
        );

        att_chan_fsm #(.CODE_W(CODE_W), .MAX_ATT(MAX_ATT), .TMO_SMP(TMO_SMP)) u_fsm (
            .clk(clk), .rst(rst), .tgt(tgt_a[ch]), .wr(wr_a[ch]),
            .mute_req(mbit_a[ch] | ~smute_n), .zc_mode(zc_mode),
            .rate_sel(rate_sel), .zdis(zmute_dis), .smp_stb(smp_stb),
            .zc(zc), .run_hit(run_hit), .nz(nz),
            .att(att_a[ch]), .muted(muted_a[ch]), .pend(pend_a[ch])
        );
    end

    assign att_l   = att_a[0];
    assign att_r   = att_a[1];
    assign muted_l = muted_a[0];
    assign muted_r = muted_a[1];
    assign pend_l  = pend_a[0];
    assign pend_r  = pend_a[1];
endmodule

// File: rtl/atten_ramp_ctrl_chk.sv
`timescale 1ns/1ps
module atten_ramp_ctrl_chk #(
    parameter int CODE_W    = 8,
    parameter int MUTE_CODE = 228
) (
    input logic              clk,
    input logic              rst,
    input logic              tgt_wr_l,
    input logic              tgt_wr_r,
    input logic              smp_stb,
    input logic              zmute_dis,
    input logic [CODE_W-1:0] att_l,
    input logic [CODE_W-1:0] att_r,
    input logic              pend_l,
    input logic              pend_r
);
    AST_CODE_RANGE_L: assert property (@(posedge clk) disable iff (rst)
        att_l <= CODE_W'(MUTE_CODE)); // R1
    AST_CODE_RANGE_R: assert property (@(posedge clk) disable iff (rst)
        att_r <= CODE_W'(MUTE_CODE)); // R1
    AST_PEND_SET_L: assert property (@(posedge clk) disable iff (rst)
        tgt_wr_l |=> pend_l); // R6
    AST_PEND_SET_R: assert property (@(posedge clk) disable iff (rst)
        tgt_wr_r |=> pend_r); // R6
    AST_QUIET_HOLD_L: assert property (@(posedge clk) disable iff (rst)
        (!smp_stb && !zmute_dis) |=> $stable(att_l)); // R4
    AST_QUIET_HOLD_R: assert property (@(posedge clk) disable iff (rst)
        (!smp_stb && !zmute_dis) |=> $stable(att_r)); // R4
endmodule

bind atten_ramp_ctrl atten_ramp_ctrl_chk #(.CODE_W(CODE_W), .MUTE_CODE(MAX_ATT + 1)) u_chk (
    .clk(clk), .rst(rst), .tgt_wr_l(tgt_wr_l), .tgt_wr_r(tgt_wr_r),
    .smp_stb(smp_stb), .zmute_dis(zmute_dis),
    .att_l(att_l), .att_r(att_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/atten_ramp_ctrl_tb.sv
`timescale 1ns/1ps
module atten_ramp_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  tgt_l = '0, tgt_r = '0;
    logic        tgt_wr_l = 1'b0, tgt_wr_r = 1'b0;
    logic [1:0]  rate_sel = '0;
    logic        zc_mode = 1'b0, mute_l = 1'b0, mute_r = 1'b0;
    logic        smute_n = 1'b1, zmute_dis = 1'b0, smp_stb = 1'b0;
    logic [19:0] smp_l = 20'h01000, smp_r = 20'h01000;
    logic [7:0]  att_l, att_r;
    logic        muted_l, muted_r, pend_l, pend_r;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    localparam logic [19:0] POS = 20'h01000;
    localparam logic [19:0] NEG = 20'hF0000;

    always #2 clk = ~clk;

    atten_ramp_ctrl u_dut (
        .clk(clk), .rst(rst), .tgt_l(tgt_l), .tgt_r(tgt_r),
        .tgt_wr_l(tgt_wr_l), .tgt_wr_r(tgt_wr_r), .rate_sel(rate_sel),
        .zc_mode(zc_mode), .mute_l(mute_l), .mute_r(mute_r),
        .smute_n(smute_n), .zmute_dis(zmute_dis), .smp_stb(smp_stb),
        .smp_l(smp_l), .smp_r(smp_r), .att_l(att_l), .att_r(att_r),
        .muted_l(muted_l), .muted_r(muted_r), .pend_l(pend_l), .pend_r(pend_r)
    );

    // behavioural reference: 0 hold, 1 ramp, 2 zero-cross wait, 3 auto-muted
    int m_cur[2], m_st[2], m_tick[2], m_tmr[2], m_run[2], m_pend[2], m_prev[2];

    always @(posedge clk) begin
        for (int ch = 0; ch < 2; ch++) begin
            int tg, eff, n, nc, ns, nt, ntm, stp;
            logic [19:0] s;
            bit wr, mt, silent, zc, hit, nzs;
            if (rst) begin
                m_cur[ch] = 0; m_st[ch] = 0; m_tick[ch] = 0; m_tmr[ch] = 0;
                m_run[ch] = 0; m_pend[ch] = 0; m_prev[ch] = 0;
            end else begin
                tg = (ch == 0) ? int'(tgt_l) : int'(tgt_r);
                s  = (ch == 0) ? smp_l : smp_r;
                wr = (ch == 0) ? tgt_wr_l : tgt_wr_r;
                mt = (ch == 0) ? mute_l : mute_r;
                eff = (mt || !smute_n || tg > 228) ? 228 : tg;
                silent = (s == 20'h0) || (s == 20'hFFFFF);
                zc  = (s == 20'h0) || (int'(s[19]) != m_prev[ch]);
                hit = smp_stb && silent && m_run[ch] == 511 && !zmute_dis;
                nzs = smp_stb && !silent;
                n = (rate_sel == 0) ? 8 : (rate_sel == 1) ? 4 : (rate_sel == 2) ? 16 : 32;
                nc = m_cur[ch]; ns = m_st[ch]; nt = m_tick[ch]; ntm = m_tmr[ch];
                if (m_st[ch] != 3 && hit) begin
                    ns = 3; nc = 228;
                end else if (m_st[ch] == 0) begin
                    if (m_cur[ch] != eff) begin
                        if (zc_mode) begin ns = 2; ntm = 0; end
                        else begin ns = 1; nt = 0; end
                    end
                end else if (m_st[ch] == 1) begin
                    if (m_cur[ch] == eff) ns = 0;
                    else if (zc_mode) begin ns = 2; ntm = 0; end
                    else if (smp_stb) begin
                        if (m_tick[ch] == n - 1) begin
                            nt = 0;
                            stp = (m_cur[ch] < eff) ? 1 : -1;
                            nc = m_cur[ch] + stp;
                            if (nc == eff) ns = 0;
                        end else nt = m_tick[ch] + 1;
                    end
                end else if (m_st[ch] == 2) begin
                    if (m_cur[ch] == eff) ns = 0;
                    else if (!zc_mode) begin ns = 1; nt = 0; end
                    else if (smp_stb && (zc || m_tmr[ch] == 511)) begin nc = eff; ns = 0; end
                    else if (wr) ntm = 0;
                    else if (smp_stb) ntm = m_tmr[ch] + 1;
                end else begin
                    if (zmute_dis || nzs) begin nc = eff; ns = 0; end
                end
                if (wr) m_pend[ch] = 1;
                else if (m_st[ch] == 0 && m_cur[ch] == eff) m_pend[ch] = 0;
                if (smp_stb) begin
                    m_prev[ch] = int'(s[19]);
                    if (!silent) m_run[ch] = 0;
                    else if (m_run[ch] != 511) m_run[ch] = m_run[ch] + 1;
                end
                m_cur[ch] = nc; m_st[ch] = ns; m_tick[ch] = nt; m_tmr[ch] = ntm;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(int'(att_l) == m_cur[0], "R2 att_l vs model", int'(att_l), m_cur[0]);
            chk(int'(att_r) == m_cur[1], "R2 att_r vs model", int'(att_r), m_cur[1]);
            chk(int'(muted_l) == int'(m_cur[0] > 227), "R1 muted_l vs model", int'(muted_l), int'(m_cur[0] > 227));
            chk(int'(muted_r) == int'(m_cur[1] > 227), "R1 muted_r vs model", int'(muted_r), int'(m_cur[1] > 227));
            chk(int'(pend_l) == m_pend[0], "R6 pend_l vs model", int'(pend_l), m_pend[0]);
            chk(int'(pend_r) == m_pend[1], "R6 pend_r vs model", int'(pend_r), m_pend[1]);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic samples(input int n, input logic [19:0] l, input logic [19:0] r);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); smp_stb = 1'b1; smp_l = l; smp_r = r;
            @(negedge clk); smp_stb = 1'b0;
        end
    endtask

    task automatic zruns(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); smp_stb = 1'b1;
            smp_l = (i % 2 == 0) ? 20'h0 : 20'hFFFFF;
            smp_r = (i % 2 == 0) ? 20'hFFFFF : 20'h0;
            @(negedge clk); smp_stb = 1'b0;
        end
    endtask

    task automatic wr_tgt(input int ch, input logic [7:0] v);
        @(negedge clk);
        if (ch == 0) begin tgt_l = v; tgt_wr_l = 1'b1; end
        else         begin tgt_r = v; tgt_wr_r = 1'b1; end
        @(negedge clk); tgt_wr_l = 1'b0; tgt_wr_r = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        idle(4); rst = 1'b0; idle(1);
        chk(att_l == 0 && att_r == 0, "R12 reset codes", int'(att_l), 0);
        chk(!pend_l && !pend_r && !muted_l && !muted_r, "R12 reset flags", int'(pend_l), 0);

        // soft ramps at each rate
        rate_sel = 2'd1; wr_tgt(0, 8'd10);
        samples(20, POS, POS); chk(att_l == 5, "R3 N=4 after 20 strobes", int'(att_l), 5);
        samples(40, POS, POS); idle(2);
        chk(att_l == 10, "R2 ramp reaches target", int'(att_l), 10);
        chk(!pend_l, "R6 pend clears when settled", int'(pend_l), 0);
        rate_sel = 2'd3; wr_tgt(1, 8'd6);
        samples(64, POS, POS); chk(att_r == 2, "R3 N=32 after 64 strobes", int'(att_r), 2);
        samples(130, POS, POS); chk(att_r == 6, "R2 ramp R to 6", int'(att_r), 6);
        rate_sel = 2'd2; wr_tgt(0, 8'd4);
        samples(32, POS, POS); chk(att_l == 8, "R3 N=16 downward", int'(att_l), 8);
        samples(70, POS, POS); chk(att_l == 4, "R2 ramp down to 4", int'(att_l), 4);
        rate_sel = 2'd0; wr_tgt(1, 8'd9);
        samples(16, POS, POS); chk(att_r == 8, "R3 N=8 after 16 strobes", int'(att_r), 8);
        samples(20, POS, POS); chk(att_r == 9, "R2 ramp R to 9", int'(att_r), 9);

        // zero-cross jump
        zc_mode = 1'b1; wr_tgt(0, 8'd40);
        samples(10, POS, POS); idle(2);
        chk(att_l == 4, "R4 no jump without crossing", int'(att_l), 4);
        chk(pend_l, "R6 pending while waiting", int'(pend_l), 1);
        samples(1, NEG, POS);
        chk(att_l == 40, "R4 jump on sign change", int'(att_l), 40);
        idle(2); chk(!pend_l, "R6 pend clears after jump", int'(pend_l), 0);

        // timeout with restart
        samples(3, NEG, POS); wr_tgt(1, 8'd20);
        samples(300, NEG, POS); chk(att_r == 9, "R5 still waiting at 300", int'(att_r), 9);
        wr_tgt(1, 8'd22);
        samples(511, NEG, POS); chk(att_r == 9, "R11 timer restarted", int'(att_r), 9);
        chk(pend_r, "R11 still pending", int'(pend_r), 1);
        samples(1, NEG, POS); chk(att_r == 22, "R5 jump at 512th strobe", int'(att_r), 22);

        // soft-mute pin
        zc_mode = 1'b0; rate_sel = 2'd1; smute_n = 1'b0;
        samples(40, NEG, POS);
        chk(att_l == 50 && att_r == 32, "R7 ramp toward mute", int'(att_l), 50);
        samples(800, NEG, POS);
        chk(att_l == 228 && att_r == 228, "R7 both at mute code", int'(att_r), 228);
        chk(muted_l && muted_r, "R1 muted flags at 228", int'(muted_l), 1);
        smute_n = 1'b1; samples(840, NEG, POS);
        chk(att_l == 40 && att_r == 22, "R7 ramp back up", int'(att_l), 40);

        // per-channel mute bit, zero-cross mode
        zc_mode = 1'b1; mute_r = 1'b1; samples(1, NEG, NEG);
        chk(att_r == 228 && muted_r, "R8 right muted", int'(att_r), 228);
        chk(att_l == 40 && !muted_l, "R8 left untouched", int'(att_l), 40);
        mute_r = 1'b0; samples(1, NEG, POS);
        chk(att_r == 22 && !muted_r, "R8 right restored", int'(att_r), 22);

        // auto-mute on silent run
        zc_mode = 1'b0; zruns(511);
        chk(att_l == 40 && !muted_l, "R9 no mute at 511", int'(att_l), 40);
        zruns(1);
        chk(att_l == 228 && att_r == 228, "R9 auto-mute at 512", int'(att_l), 228);
        samples(1, POS, POS);
        chk(att_l == 40 && att_r == 22, "R9 instant unmute", int'(att_r), 22);

        // disable auto-mute
        zmute_dis = 1'b1; zruns(600);
        chk(att_l == 40 && !muted_r, "R10 disabled auto-mute", int'(att_l), 40);
        samples(1, POS, POS); zmute_dis = 1'b0;

        // target above range
        rate_sel = 2'd1; wr_tgt(0, 8'd250); samples(760, POS, POS);
        chk(att_l == 228 && muted_l, "R1 target above 227 mutes", int'(att_l), 228);
        idle(2);
        finish_run();
    end
endmodule